// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Trigger

This block buffers bytes arriving from a serial receiver until software drains them. Each byte arrives as a one-cycle strobe with its data. A pop strobe, issued when the data register is read, consumes the oldest byte. The block keeps up to 64 bytes in arrival order. It reports three level-based conditions: the queue is empty, the queue is full, or the fill has reached a programmable threshold. When a byte is lost because the queue is full, it raises a one-cycle overflow event for a separate interrupt controller.

Reception is gated by a pair of control bits, one that enables and one that disables. The receiver accepts bytes only when the enable bit is set and the disable bit is clear. A self-clearing command bit in the same control word flushes the queue. The threshold register and the control word can both be written and read back.

All state changes at the rising clock edge. The status outputs and the head byte come from registered state, so a change appears in the cycle after the edge that caused it.

Top module: `uart_rx_fifo`

## Requirements
- R1: After synchronous reset, the control word reads 0x128, the threshold reads 0x20, the fill is 0, the receiver is off (bit 3 set), the empty flag is 1, and the full, trigger and overflow outputs are 0.
- R2: Bytes accepted into the queue come out in arrival order. `rd_data` shows the oldest byte, and a pop at an edge removes it, so the fill drops by one.
- R3: A byte that arrives while the receiver is on and the fill is 64, with no pop in the same cycle, is discarded and the queue is unchanged. `ovf_evt` is 1 for exactly the cycle after that edge.
- R4: When the fill is 64 and a byte arrives in the same cycle as a pop, the byte is accepted, the fill stays at 64, and `ovf_evt` stays 0.
- R5: `st_empty` is 1 exactly when the fill is 0. While empty, `rd_data` is 0x00, and a pop leaves the fill at 0.
- R6: `st_full` is 1 exactly when the fill is 64.
- R7: `st_trig` is 1 when the threshold is nonzero and the fill is greater than or equal to it. A threshold of 0 never triggers. The threshold is 6 bits and is written through `lvl_we`/`lvl_wdata`.
- R8: The receiver is on (`rx_on`) exactly when control bit 2 is 1 and control bit 3 is 0. A byte that arrives while it is off is dropped and never raises `ovf_evt`.
- R9: Writing the control word with bit 0 set empties the queue at that edge, and a byte arriving in the same cycle is discarded. Bits 0 and 1 always read back as 0. Bits 8 to 2 read back as written.
- R10: A control or threshold write takes effect at its edge. A byte arriving in the same cycle as an enabling write is judged with the old enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| pop | input | 1 | Consume the head byte at this edge |
| rd_data | output | 8 | Head byte, or 0x00 when empty |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word write value (bit0 flush, bit2 enable, bit3 disable) |
| ctl_rdata | output | 9 | Control word read value |
| lvl_we | input | 1 | Threshold write strobe |
| lvl_wdata | input | 6 | Threshold write value |
| lvl_rdata | output | 6 | Current threshold |
| fill | output | 7 | Number of bytes held (0 to 64) |
| rx_on | output | 1 | Receiver enabled |
| st_empty | output | 1 | Queue empty |
| st_full | output | 1 | Queue full |
| st_trig | output | 1 | Fill at or above nonzero threshold |
| ovf_evt | output | 1 | One-cycle event: a byte was lost to a full queue |

## Verification
The assertions assume every input is a defined, single-cycle synchronous strobe or value. They also assume a pop and a flush may coincide with any byte arrival, but no input changes between edges in a way that matters to the design. The stimulus changes all inputs only on the falling edge and returns every strobe to 0 after each cycle. It freely mixes pops on an empty queue, arrivals while the receiver is off, flushes during arrivals and threshold changes. All of these are legal and covered by the properties. Runs that fill the queue to 64 with arrivals and pops in the same cycle exercise the full boundary.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CTL_W  = 9;

    // control word value after reset
    localparam logic [CTL_W-1:0] CTL_RESET = 9'h128;

    // control bit positions that this block decodes
    localparam int unsigned CB_FLUSH  = 0;
    localparam int unsigned CB_TXRST  = 1;
    localparam int unsigned CB_RX_EN  = 2;
    localparam int unsigned CB_RX_DIS = 3;

    // byte returned when popping an empty queue
    localparam logic [BYTE_W-1:0] DUMMY_BYTE = '0;

    // per-cycle queue operation chosen by the admission logic
    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } rxq_op_t;

    // fate of an arriving byte
    typedef enum logic [1:0] {
        ARR_NONE     = 2'd0,
        ARR_STORED   = 2'd1,
        ARR_GATED    = 2'd2,
        ARR_OVERFLOW = 2'd3
    } rxq_arrival_e;

    typedef struct packed {
        logic empty;
        logic full;
        logic trig;
    } rxq_stat_t;

    function automatic logic rx_enabled(input logic [CTL_W-1:0] c);
        return c[CB_RX_EN] & ~c[CB_RX_DIS];
    endfunction

    // command bits are self-clearing and never stored
    function automatic logic [CTL_W-1:0] ctl_keep(input logic [CTL_W-1:0] w);
        logic [CTL_W-1:0] r;
        r = w;
        r[CB_FLUSH] = 1'b0;
        r[CB_TXRST] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned LVL_W   = 6,
    parameter logic [LVL_W-1:0] LVL_RESET = 6'h20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             lvl_we,
    input  logic [LVL_W-1:0] lvl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [LVL_W-1:0] lvl_q,
    output logic             flush,
    output logic             rx_on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_we) begin
            ctl_q <= ctl_keep(ctl_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= LVL_RESET;
        end else if (lvl_we) begin
            lvl_q <= lvl_wdata;
        end
    end

    // flush acts on the write itself; gating uses the stored word
    assign flush = ctl_we & ctl_wdata[CB_FLUSH];
    assign rx_on = rx_enabled(ctl_q);

endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
    import rxq_pkg::*;
(
    input  logic         rx_valid,
    input  logic         rx_on,
    input  logic         flush,
    input  logic         pop_req,
    input  logic         empty,
    input  logic         full,
    output rxq_op_t      op,
    output rxq_arrival_e arrival
);

    logic pop_ok;
    logic room;

    always_comb begin
        // a pop on an empty queue is a no-op; flush overrides everything
        pop_ok = pop_req & ~empty & ~flush;
        // a pop in the same cycle frees the slot the arrival needs
        room   = ~full | pop_ok;

        op.flush = flush;
        op.pop   = pop_ok;
        op.push  = 1'b0;
        arrival  = ARR_NONE;

        if (rx_valid) begin
            if (flush || !rx_on) begin
                arrival = ARR_GATED;
            end else if (room) begin
                op.push = 1'b1;
                arrival = ARR_STORED;
            end else begin
                arrival = ARR_OVERFLOW;
            end
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  rxq_op_t          op,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    localparam bit POW2 = (DEPTH == (1 << PTR_W));

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W-1:0] wr_nxt, rd_nxt;

    // pointer advance: free wrap for power-of-two depth, compare otherwise
    generate
        if (POW2) begin : g_wrap_free
            assign wr_nxt = wr_ptr + PTR_W'(1);
            assign rd_nxt = rd_ptr + PTR_W'(1);
        end else begin : g_wrap_cmp
            assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (op.push && !op.flush) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (op.push) wr_ptr <= wr_nxt;
            if (op.pop)  rd_ptr <= rd_nxt;
            unique case ({op.push, op.pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = 6,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [LVL_W-1:0] level,
    input  rxq_arrival_e     arrival,
    output rxq_stat_t        stat,
    output logic             ovf_q
);

    always_comb begin
        stat.empty = (count == '0);
        stat.full  = (CMP_W'(count) >= CMP_W'(DEPTH));
        stat.trig  = (level != '0) && (CMP_W'(count) >= CMP_W'(level));
    end

    // the lost-byte event is registered so it lines up with the status
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= (arrival == ARR_OVERFLOW);
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = 6,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             pop,
    output logic [7:0]       rd_data,
    input  logic             ctl_we,
    input  logic [8:0]       ctl_wdata,
    output logic [8:0]       ctl_rdata,
    input  logic             lvl_we,
    input  logic [LVL_W-1:0] lvl_wdata,
    output logic [LVL_W-1:0] lvl_rdata,
    output logic [CNT_W-1:0] fill,
    output logic             rx_on,
    output logic             st_empty,
    output logic             st_full,
    output logic             st_trig,
    output logic             ovf_evt
);

    logic               flush;
    rxq_op_t            op;
    rxq_arrival_e       arrival;
    rxq_stat_t          stat;
    logic [BYTE_W-1:0]  head;

    rxq_ctrl #(
        .LVL_W     (LVL_W),
        .LVL_RESET (LVL_W'(32))
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .lvl_we    (lvl_we),
        .lvl_wdata (lvl_wdata),
        .ctl_q     (ctl_rdata),
        .lvl_q     (lvl_rdata),
        .flush     (flush),
        .rx_on     (rx_on)
    );

    rxq_admit u_admit (
        .rx_valid (rx_valid),
        .rx_on    (rx_on),
        .flush    (flush),
        .pop_req  (pop),
        .empty    (stat.empty),
        .full     (stat.full),
        .op       (op),
        .arrival  (arrival)
    );

    rxq_store #(
        .DEPTH (DEPTH),
        .W     (BYTE_W)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (rx_byte),
        .head  (head),
        .count (fill)
    );

    rxq_flags #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .count   (fill),
        .level   (lvl_rdata),
        .arrival (arrival),
        .stat    (stat),
        .ovf_q   (ovf_evt)
    );

    assign st_empty = stat.empty;
    assign st_full  = stat.full;
    assign st_trig  = stat.trig;
    assign rd_data  = stat.empty ? DUMMY_BYTE : head;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LVL_W = 6,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             pop,
    input logic [7:0]       rd_data,
    input logic             ctl_we,
    input logic [8:0]       ctl_wdata,
    input logic [8:0]       ctl_rdata,
    input logic             lvl_we,
    input logic [LVL_W-1:0] lvl_wdata,
    input logic [LVL_W-1:0] lvl_rdata,
    input logic [CNT_W-1:0] fill,
    input logic             rx_on,
    input logic             st_empty,
    input logic             st_full,
    input logic             st_trig,
    input logic             ovf_evt
);

    // R3: a lost byte is only reported after a cycle spent at full fill
    a_r3_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> ($past(fill) == CNT_W'(DEPTH)));

    // R4: a pop in the same cycle always makes room
    a_r4_pop_blocks_ovf: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |-> !$past(pop));

    // R4: arrival plus pop at full keeps the queue full
    a_r4_full_swap: assert property (@(posedge clk) disable iff (rst)
        (st_full && pop && rx_valid && rx_on && !ctl_we) |=> (fill == CNT_W'(DEPTH)) && !ovf_evt);

    // R6: occupancy never exceeds capacity
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));

    // R5: popping an empty queue does not underflow
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (st_empty && pop && !rx_valid) |=> st_empty && (rd_data == 8'h00));

    // R8: with the receiver off, arrivals change nothing
    a_r8_gated_hold: assert property (@(posedge clk) disable iff (rst)
        (!rx_on && !pop && !ctl_we) |=> $stable(fill) && !ovf_evt);

    // R9: flush empties the queue; command bits read as zero
    a_r9_flush: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_wdata[0]) |=> (fill == '0) && (ctl_rdata[1:0] == 2'b00));

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_rx_fifo_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_bench;

    localparam int DEPTH = 64;
    localparam int WATCHDOG_CYCLES = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       pop = 1'b0;
    logic [7:0] rd_data;
    logic       ctl_we = 1'b0;
    logic [8:0] ctl_wdata = '0;
    logic [8:0] ctl_rdata;
    logic       lvl_we = 1'b0;
    logic [5:0] lvl_wdata = '0;
    logic [5:0] lvl_rdata;
    logic [6:0] fill;
    logic       rx_on, st_empty, st_full, st_trig, ovf_evt;

    always #4 clk = ~clk;

    uart_rx_fifo u_uart_rx_fifo (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .pop(pop),
        .rd_data(rd_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .lvl_rdata(lvl_rdata), .fill(fill),
        .rx_on(rx_on), .st_empty(st_empty), .st_full(st_full), .st_trig(st_trig),
        .ovf_evt(ovf_evt)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference state
    logic [7:0] m_q [$];
    logic [8:0] m_ctl;
    logic [5:0] m_lvl;
    logic       m_ovf;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int sz = m_q.size();
        chk("R2", "rd_data",   rd_data,   sz > 0 ? int'(m_q[0]) : 0);
        chk("R2", "fill",      fill,      sz);
        chk("R5", "st_empty",  st_empty,  sz == 0);
        chk("R6", "st_full",   st_full,   sz >= DEPTH);
        chk("R7", "st_trig",   st_trig,   (m_lvl != 0) && (sz >= int'(m_lvl)));
        chk("R3", "ovf_evt",   ovf_evt,   m_ovf);
        chk("R9", "ctl_rdata", ctl_rdata, m_ctl);
        chk("R7", "lvl_rdata", lvl_rdata, m_lvl);
        chk("R8", "rx_on",     rx_on,     m_ctl[2] & ~m_ctl[3]);
    endtask

    // one clock: drive at the falling edge, update the model at the rising
    // edge, compare at the next falling edge, then release the strobes
    task automatic step(input logic v, input logic [7:0] b, input logic p,
                        input logic cw, input logic [8:0] cd,
                        input logic lw, input logic [5:0] ld);
        int  sz;
        bit  en, popok;
        rx_valid = v; rx_byte = b; pop = p;
        ctl_we = cw; ctl_wdata = cd; lvl_we = lw; lvl_wdata = ld;
        @(posedge clk);
        sz = m_q.size();
        en = m_ctl[2] & ~m_ctl[3];
        m_ovf = 1'b0;
        if (cw && cd[0]) begin
            m_q.delete();
        end else begin
            popok = p && (sz > 0);
            if (popok) void'(m_q.pop_front());
            if (v && en) begin
                if (sz < DEPTH || popok) m_q.push_back(b);
                else m_ovf = 1'b1;
            end
        end
        if (cw) m_ctl = cd & 9'h1FC;
        if (lw) m_lvl = ld;
        @(negedge clk);
        compare_all();
        rx_valid = 0; pop = 0; ctl_we = 0; lvl_we = 0;
    endtask

    task automatic push_b(input logic [7:0] b);
        step(1, b, 0, 0, '0, 0, '0);
    endtask

    task automatic pop_b();
        step(0, '0, 1, 0, '0, 0, '0);
    endtask

    task automatic idle();
        step(0, '0, 0, 0, '0, 0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_ctl = 9'h128;
        m_lvl = 6'h20;
        m_ovf = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset values
        chk("R1", "ctl after reset",   ctl_rdata, 9'h128);
        chk("R1", "level after reset", lvl_rdata, 6'h20);
        chk("R1", "fill after reset",  fill, 0);
        chk("R1", "rx_on after reset", rx_on, 0);
        chk("R1", "empty after reset", st_empty, 1);
        chk("R1", "ovf after reset",   ovf_evt, 0);

        // R8: receiver off after reset, arrivals dropped
        push_b(8'hA1);
        push_b(8'hA2);
        chk("R8", "fill while disabled", fill, 0);

        // R10: enable written in the same cycle as an arrival: arrival dropped
        step(1, 8'h11, 0, 1, 9'h004, 0, '0);
        chk("R10", "fill after enabling write", fill, 0);

        // R2: ordered storage and drain
        for (int i = 0; i < 5; i++) push_b(8'h30 + 8'(i));
        pop_b();
        chk("R2", "head after one pop", rd_data, 8'h31);
        step(1, 8'h50, 1, 0, '0, 0, '0);
        pop_b();
        pop_b();

        // R7: threshold at 3, then zero
        step(0, '0, 0, 0, '0, 1, 6'd3);
        push_b(8'h60);
        push_b(8'h61);
        chk("R7", "trigger at level 3", st_trig, (fill >= 3) ? 1 : 0);
        step(0, '0, 0, 0, '0, 1, 6'd0);
        chk("R7", "level zero never triggers", st_trig, 0);

        // R5: drain past empty
        while (fill != 0) pop_b();
        pop_b();
        pop_b();
        chk("R5", "dummy byte on empty", rd_data, 8'h00);

        // R6/R3: fill to capacity, then overflow
        step(0, '0, 0, 0, '0, 1, 6'd63);
        for (int i = 0; i < DEPTH; i++) push_b(8'(i * 3));
        chk("R6", "full at 64", st_full, 1);
        push_b(8'hEE);
        chk("R3", "overflow pulse", ovf_evt, 1);
        chk("R3", "fill unchanged", fill, DEPTH);
        idle();
        chk("R3", "pulse lasts one cycle", ovf_evt, 0);

        // R4: arrival with pop at full
        step(1, 8'hC4, 1, 0, '0, 0, '0);
        chk("R4", "fill stays full", fill, DEPTH);
        chk("R4", "no overflow on swap", ovf_evt, 0);

        // R8: disable bit overrides enable; full queue no overflow
        step(0, '0, 0, 1, 9'h00C, 0, '0);
        push_b(8'h77);
        chk("R8", "no overflow when off", ovf_evt, 0);

        // R9: flush with a coincident arrival, command bits read zero
        step(0, '0, 0, 1, 9'h004, 0, '0);
        step(1, 8'h99, 0, 1, 9'h007, 0, '0);
        chk("R9", "flush empties", fill, 0);
        chk("R9", "command bits read zero", ctl_rdata[1:0], 0);

        // mixed traffic, push-heavy then pop-heavy
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 1500; c++) begin
                int r = $urandom_range(0, 999);
                logic v = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 80 : 30));
                logic p = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 30 : 80));
                logic cw = (r < 8);
                logic [8:0] cd = (r < 2) ? 9'h005 : ((r < 4) ? 9'h00C : 9'h004);
                logic lw = (r >= 990);
                step(v, 8'($urandom), p, cw, cd | 9'(($urandom & 32'h1F0)), lw,
                     6'($urandom));
            end
        end

        finish_run();
    end

endmodule